// File: doc/BRIEF.md
# Execute Stage with Conditional Writeback

This block is the execute step of a small 16-bit pipelined processor. Each cycle it accepts a decoded control bundle, an immediate and the instruction address from the stage before it. It reads up to two operands from an internal bank of eight 16-bit registers. It selects the two ALU inputs from registers, memory read data, a byte immediate, the instruction address or an inverted register. It then computes a result and decides whether that result is written back.

A result can be written to a register or sent out as a new program counter. A register write can update the whole word or only one byte of it. Either kind of write can depend on the zero and sign flags of the result, under a five-bit condition mask. The control bundle, the immediate, the address and the ALU result are registered and passed to the next stage. A stall input freezes the stage, and a synchronous reset returns it to a no-operation state.

Top module: `exec_stage`

## Requirements
- R1: Eight 16-bit registers, indexed 0 to 7, can be read by two read ports at once. A write takes effect at the clock edge, so the next instruction reads the new value. Reset clears every register to 0.
- R2: The first operand select (2 bits) picks the first read port for 0, `mem_rdata` for 1, `imm_in[7:0]` zero-extended for 2, and `pc_in` for 3.
- R3: The second operand select (2 bits) picks the second read port for 0, its bitwise complement for 1, and `pc_in` for 2. Code 3 gives the constant 0.
- R4: The opcode gives the result as follows: 0 = A+B, 1 = A-B (both modulo 2^16), 2 = AND, 3 = OR, 4 = XOR, 5 = A shifted left by B[3:0], 6 = A shifted right logically by B[3:0], 7 = A. Codes 8 to 15 give 0.
- R5: When both byte enables are set, the destination register gets the full result. When only the high enable is set, result[7:0] goes into bits 15:8. When only the low enable is set, result[7:0] goes into bits 7:0. A byte whose enable is clear keeps its old value.
- R6: Z is 1 when the result is 0, and S is result bit 15. With the mask written {pol, zign, sign, zreq, sreq}, a flag match is (zign or Z==zreq) and (sign or S==sreq). A write occurs only when the match equals pol.
- R7: With the destination bit set, an allowed write raises `pc_wr_valid` for one cycle, with the target on `result_out`, and no register changes. With the bit clear, `pc_wr_valid` is 0.
- R8: When `en` is 1, `ctl_out`, `imm_out`, `pc_out` and `result_out` show, one cycle later, the bundle, the immediate, the address and the ALU result of the instruction that was presented.
- R9: When `en` is 0, every output register keeps its value and no register or PC write occurs.
- R10: While `rst` is high at a clock edge, every output clears to 0, which is the no-operation bundle.
- R11: The 25-bit bundle is laid out as follows, from the most significant bit: opcode [24:21], first read index [20:18], second read index [17:15], first operand select [14:13], second operand select [12:11], PC destination [10], write index [9:7], high enable [6], low enable [5], condition mask [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; 0 stalls the stage |
| ctl_in | input | 25 | Decoded control bundle |
| imm_in | input | 16 | Immediate from decode |
| pc_in | input | 16 | Address of the instruction |
| mem_rdata | input | 16 | Memory read data operand |
| ctl_out | output | 25 | Registered control bundle |
| imm_out | output | 16 | Registered immediate |
| pc_out | output | 16 | Registered instruction address |
| result_out | output | 16 | Registered ALU result |
| pc_wr_valid | output | 1 | Registered PC redirect strobe |

## Verification
A wrong register value stays hidden until a later instruction reads that register. It then shows on `result_out` one cycle after the read. The bench therefore follows every byte write and every suppressed write with a read-back instruction. An error in operand selection, the opcode or the flag test shows on `result_out` or `pc_wr_valid` at the first edge after the instruction is presented. A fault in the stall or reset logic shows on the same edge as a changed or non-zero output.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int XLEN   = 16;
  localparam int NREG   = 8;
  localparam int RIDX   = $clog2(NREG);
  localparam int HALF   = XLEN / 2;
  localparam int SHW    = $clog2(XLEN);
  localparam int CMASKW = 5;

  typedef enum logic [1:0] {SA_REG = 2'd0, SA_MEM = 2'd1, SA_IMM8 = 2'd2, SA_PC = 2'd3} src_a_e;
  typedef enum logic [1:0] {SB_REG = 2'd0, SB_INV = 2'd1, SB_PC = 2'd2, SB_ZERO = 2'd3} src_b_e;

  typedef struct packed {
    logic [3:0]        op;
    logic [RIDX-1:0]   ra;
    logic [RIDX-1:0]   rb;
    src_a_e            sa;
    src_b_e            sb;
    logic              to_pc;
    logic [RIDX-1:0]   dst;
    logic              wr_hi;
    logic              wr_lo;
    logic [CMASKW-1:0] cond;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [XLEN-1:0] alu_fn(input logic [3:0] op,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    case (op)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a & b;
      4'd3:    return a | b;
      4'd4:    return a ^ b;
      4'd5:    return a << sh;
      4'd6:    return a >> sh;
      4'd7:    return a;
      default: return '0;
    endcase
  endfunction

  // cond = {pol, zign, sign, zreq, sreq}
  function automatic logic cond_pass(input logic [CMASKW-1:0] cond,
                                     input logic z, input logic s);
    logic hit;
    hit = (cond[3] || (z == cond[1])) && (cond[2] || (s == cond[0]));
    return hit == cond[4];
  endfunction

  function automatic logic [XLEN-1:0] merge_bytes(input logic [XLEN-1:0] old,
                                                  input logic [XLEN-1:0] res,
                                                  input logic hi, input logic lo);
    case ({hi, lo})
      2'b11:   return res;
      2'b10:   return {res[HALF-1:0], old[HALF-1:0]};
      2'b01:   return {old[XLEN-1:HALF], res[HALF-1:0]};
      default: return old;
    endcase
  endfunction
endpackage

// File: rtl/exec_regfile.sv
module exec_regfile
  import exec_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NR = NREG,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_hi,
  input  logic          wr_lo
);
  logic [DW-1:0] bank [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic hit;
    assign hit = we && (wr_idx == AW'(g));
    always_ff @(posedge clk) begin
      if (rst)      bank[g] <= '0;
      else if (hit) bank[g] <= merge_bytes(bank[g], wr_data, wr_hi, wr_lo);
    end
  end

  assign rd_a = bank[rd_idx_a];
  assign rd_b = bank[rd_idx_b];
endmodule

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
  import exec_pkg::*;
#(
  parameter int DW = XLEN,
  localparam int HW = DW / 2
) (
  input  src_a_e        sel_a,
  input  src_b_e        sel_b,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  input  logic [DW-1:0] mem_data,
  input  logic [HW-1:0] imm8,
  input  logic [DW-1:0] pc,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  always_comb begin
    case (sel_a)
      SA_REG:  opnd_a = rd_a;
      SA_MEM:  opnd_a = mem_data;
      SA_IMM8: opnd_a = {{(DW-HW){1'b0}}, imm8};
      default: opnd_a = pc;
    endcase
  end

  always_comb begin
    case (sel_b)
      SB_REG:  opnd_b = rd_b;
      SB_INV:  opnd_b = ~rd_b;
      SB_PC:   opnd_b = pc;
      default: opnd_b = '0;
    endcase
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          flag_z,
  output logic          flag_s
);
  assign res    = alu_fn(op, a, b);
  assign flag_z = ~|res;
  assign flag_s = res[DW-1];
endmodule

// File: rtl/exec_wb_ctl.sv
module exec_wb_ctl
  import exec_pkg::*;
(
  input  logic              en,
  input  logic [CMASKW-1:0] cond,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              to_pc,
  input  logic              wr_hi,
  input  logic              wr_lo,
  output logic              cond_ok,
  output logic              rf_we,
  output logic              pc_we
);
  assign cond_ok = cond_pass(cond, flag_z, flag_s);
  assign rf_we   = en && cond_ok && !to_pc && (wr_hi || wr_lo);
  assign pc_we   = en && cond_ok && to_pc;
endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic [XLEN-1:0]  imm_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [CTL_W-1:0] ctl_out,
  output logic [XLEN-1:0]  imm_out,
  output logic [XLEN-1:0]  pc_out,
  output logic [XLEN-1:0]  result_out,
  output logic             pc_wr_valid
);
  ctl_t            cur;
  logic [XLEN-1:0] rd_a, rd_b, opnd_a, opnd_b, alu_res;
  logic            flag_z, flag_s, cond_ok, rf_we, pc_we;

  assign cur = ctl_in;

  exec_regfile #(.DW(XLEN), .NR(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .rd_idx_a(cur.ra), .rd_idx_b(cur.rb),
    .rd_a(rd_a), .rd_b(rd_b),
    .we(rf_we), .wr_idx(cur.dst), .wr_data(alu_res),
    .wr_hi(cur.wr_hi), .wr_lo(cur.wr_lo)
  );

  exec_operand_sel #(.DW(XLEN)) u_sel (
    .sel_a(cur.sa), .sel_b(cur.sb),
    .rd_a(rd_a), .rd_b(rd_b),
    .mem_data(mem_rdata), .imm8(imm_in[HALF-1:0]), .pc(pc_in),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  exec_alu #(.DW(XLEN)) u_alu (
    .op(cur.op), .a(opnd_a), .b(opnd_b),
    .res(alu_res), .flag_z(flag_z), .flag_s(flag_s)
  );

  exec_wb_ctl u_wb (
    .en(en), .cond(cur.cond), .flag_z(flag_z), .flag_s(flag_s),
    .to_pc(cur.to_pc), .wr_hi(cur.wr_hi), .wr_lo(cur.wr_lo),
    .cond_ok(cond_ok), .rf_we(rf_we), .pc_we(pc_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_out     <= '0;
      imm_out     <= '0;
      pc_out      <= '0;
      result_out  <= '0;
      pc_wr_valid <= 1'b0;
    end else if (en) begin
      ctl_out     <= ctl_in;
      imm_out     <= imm_in;
      pc_out      <= pc_in;
      result_out  <= alu_res;
      pc_wr_valid <= pc_we;
    end
  end
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
  import exec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CTL_W-1:0] ctl_in,
  input logic [CTL_W-1:0] ctl_out,
  input logic [XLEN-1:0]  imm_out,
  input logic [XLEN-1:0]  pc_out,
  input logic [XLEN-1:0]  result_out,
  input logic             pc_wr_valid,
  input logic             rf_we,
  input logic             pc_we,
  input logic             cond_ok
);
  ctl_t cin, cout;
  assign cin  = ctl_in;
  assign cout = ctl_out;

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (ctl_out == '0 && result_out == '0 && imm_out == '0 && pc_out == '0 && !pc_wr_valid));

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(ctl_out) && $stable(result_out) && $stable(imm_out) && $stable(pc_out)
             && $stable(pc_wr_valid)));

  assert_stall_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!rf_we && !pc_we));

  assert_single_dest_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, pc_we}));

  assert_redirect_tag_R7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_valid |-> cout.to_pc);

  assert_byte_enable_R5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (cin.wr_hi || cin.wr_lo));

  assert_cond_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |-> (!rf_we && !pc_we));

  assert_bundle_advance_R8: assert property (@(posedge clk) disable iff (rst)
    en |=> (ctl_out == $past(ctl_in)));
endmodule

bind exec_stage exec_stage_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .ctl_in(ctl_in), .ctl_out(ctl_out),
  .imm_out(imm_out), .pc_out(pc_out), .result_out(result_out),
  .pc_wr_valid(pc_wr_valid), .rf_we(rf_we), .pc_we(pc_we), .cond_ok(cond_ok)
);

// File: tb/exec_stage_tb_top.sv
module exec_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam logic [4:0] ALW = 5'b11100;
  localparam logic [4:0] NEV = 5'b01100;

  typedef struct packed {
    logic [24:0] ctl;
    logic [15:0] imm;
    logic [15:0] pc;
    logic [15:0] mem;
    logic [15:0] res;
    logic        pcv;
  } vec_t;

  // R11 layout: {op, ra, rb, sa, sb, to_pc, dst, hi, lo, cond}
  function automatic logic [24:0] mkc(input logic [3:0] op, input logic [2:0] ra,
      input logic [2:0] rb, input logic [1:0] sa, input logic [1:0] sb,
      input logic topc, input logic [2:0] dst, input logic hi, input logic lo,
      input logic [4:0] cnd);
    return {op, ra, rb, sa, sb, topc, dst, hi, lo, cnd};
  endfunction

  localparam vec_t VEC [NV] = '{
    '{mkc(7,0,0,2,0,0,1,1,1,ALW), 16'h1234, 16'h0000, 16'h0000, 16'h0034, 1'b0},
    '{mkc(7,0,0,1,0,0,2,1,1,ALW), 16'h0000, 16'h0002, 16'h8001, 16'h8001, 1'b0},
    '{mkc(0,1,2,0,0,0,3,1,1,ALW), 16'h0000, 16'h0004, 16'h0000, 16'h8035, 1'b0},
    '{mkc(1,3,1,0,0,0,4,1,1,ALW), 16'h0000, 16'h0006, 16'h0000, 16'h8001, 1'b0},
    '{mkc(3,1,2,0,1,0,5,1,1,ALW), 16'h0000, 16'h0008, 16'h0000, 16'h7FFE, 1'b0},
    '{mkc(5,1,0,0,2,0,6,1,1,ALW), 16'h0000, 16'h0004, 16'h0000, 16'h0340, 1'b0},
    '{mkc(6,2,0,0,2,0,7,1,1,NEV), 16'h0000, 16'h0003, 16'h0000, 16'h1000, 1'b0},
    '{mkc(7,0,0,3,0,1,0,0,0,ALW), 16'h0000, 16'h0ABC, 16'h0000, 16'h0ABC, 1'b1},
    '{mkc(0,0,0,2,2,1,0,0,0,5'b10110), 16'h0010, 16'h0100, 16'h0000, 16'h0110, 1'b0},
    '{mkc(15,0,0,0,0,1,0,0,0,5'b10110), 16'h0000, 16'h0102, 16'h0000, 16'h0000, 1'b1},
    '{mkc(4,1,2,0,0,0,7,1,1,5'b01001), 16'h0000, 16'h0104, 16'h0000, 16'h8035, 1'b0},
    '{mkc(7,7,0,0,0,0,0,0,0,NEV), 16'h0000, 16'h0106, 16'h0000, 16'h0000, 1'b0},
    '{mkc(7,0,0,2,0,0,1,1,0,ALW), 16'h00AB, 16'h0108, 16'h0000, 16'h00AB, 1'b0},
    '{mkc(7,1,0,0,0,0,0,0,0,NEV), 16'h0000, 16'h010A, 16'h0000, 16'hAB34, 1'b0},
    '{mkc(7,0,0,2,0,0,2,0,1,ALW), 16'h005C, 16'h010C, 16'h0000, 16'h005C, 1'b0},
    '{mkc(0,2,0,0,3,0,0,0,0,NEV), 16'h0000, 16'h010E, 16'h0000, 16'h805C, 1'b0},
    '{mkc(0,0,4,2,0,0,0,0,0,NEV), 16'h0000, 16'h0110, 16'h0000, 16'h8001, 1'b0},
    '{mkc(2,5,6,0,0,0,0,0,0,NEV), 16'h0000, 16'h0112, 16'h0000, 16'h0340, 1'b0},
    '{mkc(1,0,0,2,2,0,3,1,1,5'b11001), 16'h0005, 16'h0007, 16'h0000, 16'hFFFE, 1'b0},
    '{mkc(7,3,0,0,0,0,0,0,0,NEV), 16'h0000, 16'h0114, 16'h0000, 16'hFFFE, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [24:0] ctl_in = '0, ctl_out;
  logic [15:0] imm_in = '0, pc_in = '0, mem_rdata = '0;
  logic [15:0] imm_out, pc_out, result_out;
  logic        pc_wr_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_stage dut_i (
    .clk(clk), .rst(rst), .en(en), .ctl_in(ctl_in), .imm_in(imm_in),
    .pc_in(pc_in), .mem_rdata(mem_rdata), .ctl_out(ctl_out), .imm_out(imm_out),
    .pc_out(pc_out), .result_out(result_out), .pc_wr_valid(pc_wr_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [24:0] c, input logic [15:0] im, input logic [15:0] p,
                      input logic [15:0] m, input logic e);
    @(negedge clk);
    ctl_in = c; imm_in = im; pc_in = p; mem_rdata = m; en = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [15:0] held_res;
    logic [24:0] held_ctl;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset ctl_out", 32'(ctl_out), 32'h0);
    chk("R10 reset result/imm/pc", {result_out, imm_out | pc_out}, 32'h0);
    chk("R10 reset pc_wr_valid", 32'(pc_wr_valid), 32'h0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ctl, VEC[i].imm, VEC[i].pc, VEC[i].mem, 1'b1);
      chk($sformatf("R1 R2 R3 R4 R5 R6 result vector %0d", i), 32'(result_out), 32'(VEC[i].res));
      chk($sformatf("R7 pc_wr_valid vector %0d", i), 32'(pc_wr_valid), 32'(VEC[i].pcv));
      chk($sformatf("R8 R11 ctl_out vector %0d", i), 32'(ctl_out), 32'(VEC[i].ctl));
      chk($sformatf("R8 imm/pc pass vector %0d", i), {imm_out, pc_out}, {VEC[i].imm, VEC[i].pc});
    end

    // R9: stall with a full write to r1 and a PC redirect offered
    held_res = result_out;
    held_ctl = ctl_out;
    step(mkc(7,0,0,2,0,0,1,1,1,ALW), 16'h0077, 16'h0200, 16'h0000, 1'b0);
    chk("R9 stall result held", 32'(result_out), 32'(held_res));
    chk("R9 stall ctl held", 32'(ctl_out), 32'(held_ctl));
    step(mkc(7,0,0,3,0,1,0,0,0,ALW), 16'h0000, 16'h0300, 16'h0000, 1'b0);
    chk("R9 stall no redirect", 32'(pc_wr_valid), 32'h0);
    step(mkc(7,1,0,0,0,0,0,0,0,NEV), 16'h0000, 16'h0202, 16'h0000, 1'b1);
    chk("R9 stalled write dropped r1", 32'(result_out), 32'hAB34);

    // R10/R1: reset in mid run clears outputs and registers
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R10 mid reset outputs", {result_out, 15'h0, pc_wr_valid}, 32'h0);
    chk("R10 mid reset ctl_out", 32'(ctl_out), 32'h0);
    @(negedge clk) rst = 1'b0;
    step(mkc(7,1,0,0,0,0,0,0,0,NEV), 16'h0000, 16'h0204, 16'h0000, 1'b1);
    chk("R1 reset cleared r1", 32'(result_out), 32'h0);
    step(mkc(0,3,3,0,1,0,0,0,0,NEV), 16'h0000, 16'h0206, 16'h0000, 1'b1);
    chk("R1 R3 r3 cleared, r3 + ~r3", 32'(result_out), 32'hFFFF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule